// File: doc/BRIEF.md
# Floating-Point Compare-and-Set-Flag Unit

This unit compares two IEEE-754 values and stores the outcome in a one-bit condition flag. Both operands arrive on 64-bit buses. A single-precision compare reads only bits 31:0 of each bus. A double-precision compare reads all 64 bits. An 8-bit sub-opcode selects the precision and the relation. A single-cycle valid strobe qualifies the sub-opcode and the operands.

Six ordered relations are available: equal, not-equal, greater, greater-or-equal, less and less-or-equal. Each relation also has an unordered variant, which additionally sets the flag when either operand is NaN. A separate test sets the flag only when the operands are unordered. The compare logic is combinational and feeds a registered flag. A registered pulse marks each cycle in which the flag takes a new result. A sub-opcode that is not legal leaves the flag unchanged.

Top module: `fcmp_flag_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `flag` and `flag_vld` are both 0.
- R2: A legal compare presented with `in_vld` high at clock edge N appears on `flag` after edge N. `flag_vld` is high for exactly the cycles that follow such edges. Back-to-back strobes give back-to-back results.
- R3: The sub-opcode is decoded as follows:
  - Bits 7:6 must be 0 and bit 3 must be 1.
  - Bit 4 selects double precision.
  - Bit 5 selects the unordered variant.
  - Bits 2:0 select the relation: 0 eq, 1 ne, 2 gt, 3 ge, 4 lt, 5 le, 6 unordered-test.
  - This gives ordered single codes 0x08–0x0D, ordered double codes 0x18–0x1D, unordered single codes 0x28–0x2E and unordered double codes 0x38–0x3E.
- R4: A single-precision compare ignores bits 63:32 of both operand buses.
- R5: An operand is NaN when its exponent field is all ones and its fraction is nonzero. An infinity is not NaN.
- R6: If either operand is NaN, every ordered relation yields 0, except ne, which yields 1.
- R7: An unordered-variant relation yields (either operand NaN) OR (the ordered relation result).
- R8: The unordered-test code (low bits 6) yields 1 exactly when at least one operand is NaN.
- R9: +0 and -0 compare equal, and neither is less than the other.
- R10: Values that are not NaN are ordered by sign, then by magnitude. The magnitude order is reversed when both values are negative, and infinities take part in the same ordering.
- R11: A strobe carrying an illegal sub-opcode leaves `flag` unchanged and produces no `flag_vld` pulse. Illegal codes are 0x0E, 0x1E, any code with bit 3 clear, any code with bits 2:0 equal to 7, and any code with bits 7:6 nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Strobe qualifying the sub-opcode and operands |
| in_opc | input | 8 | Compare sub-opcode |
| in_a | input | 64 | First operand (single precision in bits 31:0) |
| in_b | input | 64 | Second operand (single precision in bits 31:0) |
| flag | output | 1 | Registered condition flag |
| flag_vld | output | 1 | One-cycle pulse when the flag takes a new result |

## Verification
All state sits in two flip-flops, so a wrong internal value shows at the ports one clock edge after the strobe that caused it. It shows either as a wrong flag or as a missing or extra `flag_vld` pulse. A fault in decoding or in NaN classification stays invisible until a vector uses the affected code or operand class. For that reason the bench covers every relation in both precisions, with NaN, infinity and signed-zero operands. A fault in the hold path shows only when an illegal strobe follows a flag value that the faulty decode would have overwritten. The bench therefore sets the flag first and then sends codes whose wrong decoding would clear it.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
  localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_GT  = 3'd2,
    REL_GE  = 3'd3,
    REL_LT  = 3'd4,
    REL_LE  = 3'd5,
    REL_UN  = 3'd6,
    REL_RSV = 3'd7
  } rel_e;

  typedef struct packed {
    logic legal;
    logic dbl;
    logic unord;
    rel_e rel;
  } dec_t;

  // Per-precision compare facts: unordered, equal, a strictly below b
  typedef struct packed {
    logic un;
    logic eq;
    logic lt;
  } cmp_t;

endpackage

// File: rtl/fcmp_decode.sv
module fcmp_decode
  import fcmp_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  localparam int HI_W = OPC_W - 6;

  logic hi_zero;
  rel_e rel;

  assign hi_zero = (opc[OPC_W-1:6] == {HI_W{1'b0}});
  assign rel     = rel_e'(opc[2:0]);

  always_comb begin
    dec.rel   = rel;
    dec.dbl   = opc[4];
    dec.unord = opc[5];
    dec.legal = hi_zero && opc[3] && (rel != REL_RSV) &&
                !((rel == REL_UN) && !opc[5]);
  end

endmodule

// File: rtl/fcmp_core.sv
module fcmp_core
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output cmp_t                 res
);

  localparam int MAG_W = EXP_W + MAN_W;

  logic             sa, sb;
  logic [MAG_W-1:0] ma, mb;
  logic             nan_a, nan_b, za, zb, both_zero, un, below;

  assign sa = a[MAG_W];
  assign sb = b[MAG_W];
  assign ma = a[MAG_W-1:0];
  assign mb = b[MAG_W-1:0];

  assign nan_a = (&ma[MAG_W-1:MAN_W]) && (|ma[MAN_W-1:0]);
  assign nan_b = (&mb[MAG_W-1:MAN_W]) && (|mb[MAN_W-1:0]);
  assign za    = (ma == '0);
  assign zb    = (mb == '0);

  assign both_zero = za && zb;
  assign un        = nan_a || nan_b;

  always_comb begin
    if (sa != sb)  below = sa;
    else if (sa)   below = (mb < ma);
    else           below = (ma < mb);
  end

  always_comb begin
    res.un = un;
    res.eq = !un && ((a == b) || both_zero);
    res.lt = !un && !both_zero && below;
  end

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int OPW   = 64,
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [OPC_W-1:0] in_opc,
  input  logic [OPW-1:0]   in_a,
  input  logic [OPW-1:0]   in_b,
  output logic             flag,
  output logic             flag_vld
);

  dec_t dec;
  cmp_t cmp_sp, cmp_dp, sel;
  logic rel_hit, result, take;

  fcmp_decode #(.OPC_W(OPC_W)) u_dec (
    .opc (in_opc),
    .dec (dec)
  );

  fcmp_core #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_sp (
    .a   (in_a[SP_W-1:0]),
    .b   (in_b[SP_W-1:0]),
    .res (cmp_sp)
  );

  fcmp_core #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_dp (
    .a   (in_a[DP_W-1:0]),
    .b   (in_b[DP_W-1:0]),
    .res (cmp_dp)
  );

  assign sel = dec.dbl ? cmp_dp : cmp_sp;

  always_comb begin
    unique case (dec.rel)
      REL_EQ:  rel_hit = sel.eq;
      REL_NE:  rel_hit = !sel.eq;
      REL_GT:  rel_hit = !sel.un && !sel.eq && !sel.lt;
      REL_GE:  rel_hit = !sel.un && !sel.lt;
      REL_LT:  rel_hit = sel.lt;
      REL_LE:  rel_hit = sel.lt || sel.eq;
      default: rel_hit = 1'b0;
    endcase
  end

  assign result = (dec.unord && sel.un) || rel_hit;
  assign take   = in_vld && dec.legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      flag_vld <= 1'b0;
    end else begin
      flag_vld <= take;
      if (take) flag <= result;
    end
  end

  // A NaN compare is never equal or ordered
  assert_nan_excl_R6: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> !(sel.un && (sel.eq || sel.lt)));

  // Equal and less-than are exclusive
  assert_order_excl_R10: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> !(sel.eq && sel.lt));

  // Unordered variant with a NaN operand must raise the flag
  assert_unord_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (take && dec.unord && sel.un) |=> flag);

  // Ordered not-equal with a NaN operand must raise the flag
  assert_ne_nan_R6: assert property (@(posedge clk) disable iff (rst)
    (take && !dec.unord && (dec.rel == REL_NE) && sel.un) |=> flag);

  // No strobe, no pulse
  assert_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !flag_vld);

  // Illegal code holds the flag and gives no pulse
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !dec.legal) |=> ($stable(flag) && !flag_vld));

  // The unordered-test code only decodes with the unordered bit set
  assert_un_code_R3: assert property (@(posedge clk) disable iff (rst)
    (dec.legal && dec.rel == REL_UN) |-> dec.unord);

endmodule

// File: tb/sim_fcmp_flag_unit.sv
`timescale 1ns/1ps
module sim_fcmp_flag_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [7:0]  in_opc = 8'h00;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        flag, flag_vld;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fcmp_flag_unit u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_opc(in_opc),
    .in_a(in_a), .in_b(in_b), .flag(flag), .flag_vld(flag_vld)
  );

  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VT [NV] = '{
    '{8'h08, 64'h3F800000, 64'h3F800000, 1'b1, 4'd3},  // R3 eq s
    '{8'h08, 64'h3F800000, 64'h40000000, 1'b0, 4'd3},  // R3
    '{8'h09, 64'h3F800000, 64'h40000000, 1'b1, 4'd3},  // R3 ne
    '{8'h0A, 64'h40000000, 64'h3F800000, 1'b1, 4'd3},  // R3 gt
    '{8'h0B, 64'h3F800000, 64'h3F800000, 1'b1, 4'd3},  // R3 ge
    '{8'h0C, 64'hC0000000, 64'hBF800000, 1'b1, 4'd10}, // R10 -2<-1
    '{8'h0D, 64'hBF800000, 64'hC0000000, 1'b0, 4'd10}, // R10
    '{8'h0C, 64'hBF800000, 64'h7F800000, 1'b1, 4'd10}, // R10 -1<+inf
    '{8'h0A, 64'hFF800000, 64'hC0000000, 1'b0, 4'd10}, // R10 -inf
    '{8'h08, 64'h00000000, 64'h80000000, 1'b1, 4'd9},  // R9
    '{8'h0C, 64'h80000000, 64'h00000000, 1'b0, 4'd9},  // R9
    '{8'h08, 64'h7FC00000, 64'h7FC00000, 1'b0, 4'd6},  // R6
    '{8'h09, 64'h7FC00000, 64'h3F800000, 1'b1, 4'd6},  // R6 ne
    '{8'h0B, 64'h3F800000, 64'h7FC00000, 1'b0, 4'd6},  // R6
    '{8'h28, 64'h7FC00000, 64'h3F800000, 1'b1, 4'd7},  // R7 ueq
    '{8'h2A, 64'h3F800000, 64'h40000000, 1'b0, 4'd7},  // R7 ugt
    '{8'h2A, 64'h40000000, 64'h3F800000, 1'b1, 4'd7},  // R7
    '{8'h2B, 64'h3F800000, 64'h40000000, 1'b0, 4'd7},  // R7 uge
    '{8'h2E, 64'h3F800000, 64'h40000000, 1'b0, 4'd8},  // R8
    '{8'h2E, 64'h7F800001, 64'h3F800000, 1'b1, 4'd5},  // R5 small NaN
    '{8'h2E, 64'h7F800000, 64'hFF800000, 1'b0, 4'd5},  // R5 inf
    '{8'h1A, 64'h4000000000000000, 64'h3FF0000000000000, 1'b1, 4'd3}, // R3 gt d
    '{8'h1C, 64'hC000000000000000, 64'hBFF0000000000000, 1'b1, 4'd10},// R10 d
    '{8'h18, 64'h0000000000000000, 64'h8000000000000000, 1'b1, 4'd9}, // R9 d
    '{8'h18, 64'h3FF0000000000000, 64'h3FF0000000000001, 1'b0, 4'd3}, // R3 d
    '{8'h3E, 64'h3FF0000000000000, 64'h7FF8000000000000, 1'b1, 4'd8}, // R8 d
    '{8'h3C, 64'h7FF8000000000000, 64'h3FF0000000000000, 1'b1, 4'd7}, // R7 d
    '{8'h1D, 64'h7FF8000000000000, 64'h7FF8000000000000, 1'b0, 4'd6}, // R6 d
    '{8'h08, 64'hDEADBEEF3F800000, 64'h000000003F800000, 1'b1, 4'd4}, // R4
    '{8'h0A, 64'h0000000040000000, 64'h7FF800003F800000, 1'b1, 4'd4}  // R4
  };

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_opc = op; in_a = a; in_b = b; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag in reset", flag, 1'b0);
    check("R1 flag_vld in reset", flag_vld, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 flag after reset", flag, 1'b0);
    check("R1 flag_vld after reset", flag_vld, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].op, VT[i].a, VT[i].b);
      check($sformatf("R%0d vec%0d flag", VT[i].req, i), flag, VT[i].exp);
      check($sformatf("R2 vec%0d flag_vld", i), flag_vld, 1'b1);
    end

    // R2: single pulse, then idle
    @(negedge clk);
    check("R2 pulse ends", flag_vld, 1'b0);
    repeat (2) @(negedge clk);
    check("R2 idle no pulse", flag_vld, 1'b0);

    // R2: back-to-back strobes
    @(negedge clk);
    in_opc = 8'h08; in_a = 64'h3F800000; in_b = 64'h3F800000; in_vld = 1'b1;
    @(negedge clk);
    check("R2 b2b first flag", flag, 1'b1);
    check("R2 b2b first vld", flag_vld, 1'b1);
    in_b = 64'h40000000;
    @(negedge clk);
    check("R2 b2b second flag", flag, 1'b0);
    check("R2 b2b second vld", flag_vld, 1'b1);
    in_vld = 1'b0;
    @(negedge clk);
    check("R2 b2b end", flag_vld, 1'b0);

    // R11: set flag, then illegal codes whose misdecode would clear it
    apply(8'h08, 64'h3F800000, 64'h3F800000);
    check("R11 setup", flag, 1'b1);
    foreach (ILL[k]) begin
      apply(ILL[k], 64'h3F800000, 64'h40000000);
      check($sformatf("R11 code %02h flag", ILL[k]), flag, 1'b1);
      check($sformatf("R11 code %02h vld", ILL[k]), flag_vld, 1'b0);
    end

    // R1: reset clears a set flag
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset flag", flag, 1'b0);
    check("R1 mid-run reset vld", flag_vld, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [7:0] ILL [6] = '{8'h0E, 8'h1E, 8'h1F, 8'h07, 8'h48, 8'hC8};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule